// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a set of level-sensitive interrupt sources and steers them to a small number of processor contexts. Each source has a programmable priority. Each context has its own enable mask, a priority threshold and an interrupt output line. A processor takes an interrupt by reading its context's claim register. That read returns the most urgent eligible source and holds the source in service. The processor ends service by writing the same source number back to the same register.

Each source passes through a gateway. Once a request from a source has been claimed, the gateway forwards nothing more from that source until service ends. Software reaches all registers through a simple port that does one access per cycle. Read data is registered. Source number 0 is reserved: its priority, enable and pending state always read as zero, and a claim result of 0 means nothing is waiting.

Top module: `irq_hub`

## Requirements
- R1: After reset, all priorities, enable bits and thresholds read 0, every interrupt line is low, and a claim read returns 0.
- R2: The priority of source n sits at byte address 4*n and keeps only the low 3 bits written. The slot for source 0 reads 0 and ignores writes.
- R3: The enable word w of context c sits at 0x2000 + 0x80*c + 4*w. Source n is bit (n mod 32) of word (n div 32). Bit 0 of word 0 always reads 0.
- R4: The threshold of context c sits at 0x200000 + 0x1000*c and keeps the low 3 bits. The claim/complete register of context c sits 4 bytes above it.
- R5: The interrupt line of a context is high exactly when some pending source enabled in that context has a priority strictly above the context's threshold. The line follows that condition one cycle later. A threshold of 7 keeps the line low.
- R6: A claim read returns the number of the pending, enabled source with the highest priority that is strictly above the threshold. On a tie the lower number wins. A source with priority 0 is never returned, and 0 is returned when no source qualifies.
- R7: A claim clears the returned source's pending bit and puts the source in service. While it is in service, that source cannot become pending again, even if its input stays high.
- R8: Writing source number n to a context's claim/complete register ends service of n when n is enabled in that context. If the input of n is still high, n is pending again one cycle after the write.
- R9: A completion write is ignored when the source is not enabled in the writing context. The source then stays in service.
- R10: Reads of any unmapped or unaligned address return 0, and writes to such addresses change nothing.
- R11: Read data and rd_valid appear in the cycle after the read request and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Level of each source; bit n is source n (1..NUM_SRC) |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | DATA_W | Registered read data |
| ctx_irq | output | NUM_CTX | Registered interrupt line, one per context |

## Verification
Two events can fall on the same clock edge: a completion write that ends service, and the gateway re-sampling a source input that is still high. The bench completes a held-high source and issues a claim read in the very next cycle. That read must return 0, because the gateway only sets pending at that same edge. A claim read one cycle later must return the source. The bench also sends a completion from a context that does not enable the source, then checks through later claim reads that the source stays locked.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Address map bases and strides, in bytes
  localparam int PRIO_STRIDE  = 4;
  localparam int EN_BASE      = 'h2000;
  localparam int EN_STRIDE    = 'h80;
  localparam int CT_BASE      = 'h200000;
  localparam int CT_STRIDE    = 'h1000;
  localparam int CT_THR_OFS   = 0;
  localparam int CT_CLAIM_OFS = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_EN,
    SEL_THR,
    SEL_CLAIM
  } sel_e;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [$clog2(NUM_SRC+1)-1:0] idx,
  output logic [((NUM_CTX > 1) ? $clog2(NUM_CTX) : 1)-1:0] ctx
);
  localparam int IDW      = $clog2(NUM_SRC+1);
  localparam int CW       = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
  localparam int EN_WORDS = (NUM_SRC + DATA_W) / DATA_W;
  localparam logic [ADDR_W-1:0] A_PRIO_END = ADDR_W'(PRIO_STRIDE * (NUM_SRC + 1));
  localparam logic [ADDR_W-1:0] A_EN_BASE  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] A_EN_END   = ADDR_W'(EN_BASE + EN_STRIDE * NUM_CTX);
  localparam logic [ADDR_W-1:0] A_CT_BASE  = ADDR_W'(CT_BASE);
  localparam logic [ADDR_W-1:0] A_CT_END   = ADDR_W'(CT_BASE + CT_STRIDE * NUM_CTX);
  localparam int EN_SH = $clog2(EN_STRIDE);
  localparam int CT_SH = $clog2(CT_STRIDE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] sub;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    ctx = '0;
    off = '0;
    sub = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr < A_PRIO_END) begin
        sel = SEL_PRIO;
        idx = IDW'(addr >> 2);
      end else if (addr >= A_EN_BASE && addr < A_EN_END) begin
        off = addr - A_EN_BASE;
        sub = off & ADDR_W'(EN_STRIDE - 1);
        ctx = CW'(off >> EN_SH);
        if (sub < ADDR_W'(EN_WORDS * 4)) begin
          sel = SEL_EN;
          idx = IDW'(sub >> 2);
        end
      end else if (addr >= A_CT_BASE && addr < A_CT_END) begin
        off = addr - A_CT_BASE;
        sub = off & ADDR_W'(CT_STRIDE - 1);
        ctx = CW'(off >> CT_SH);
        if (sub == ADDR_W'(CT_THR_OFS))
          sel = SEL_THR;
        else if (sub == ADDR_W'(CT_CLAIM_OFS))
          sel = SEL_CLAIM;
      end
    end
  end

endmodule

// File: rtl/irq_hub_gate.sv
module irq_hub_gate (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic take,
  input  logic done,
  output logic pend,
  output logic busy
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else if (take) begin
      pend <= 1'b0;
      busy <= 1'b1;
    end else begin
      if (lvl && !busy) pend <= 1'b1;
      if (done)         busy <= 1'b0;
    end
  end

  // R7: a source in service never shows as pending
  p_busy_no_pend_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pend);

  // R6: the claim logic only takes a pending source
  p_take_pend_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> pend);

  // R8: end of service with the input still high re-pends on the next edge
  p_repend_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && lvl) |=> pend);

endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_SRC:1]            pend,
  input  logic [NUM_SRC:1]            en,
  input  logic [NUM_SRC*PRIO_W-1:0]   prio,
  input  logic [PRIO_W-1:0]           thr,
  output logic [$clog2(NUM_SRC+1)-1:0] win_id,
  output logic                        win_valid
);
  localparam int IDW = $clog2(NUM_SRC+1);

  logic [PRIO_W-1:0] best_p;
  logic [IDW-1:0]    best_i;

  // Strictly greater keeps the lower number on a tie; priority 0 never wins
  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (pend[i] && en[i] && prio[(i-1)*PRIO_W +: PRIO_W] > best_p) begin
        best_p = prio[(i-1)*PRIO_W +: PRIO_W];
        best_i = IDW'(i);
      end
    end
    win_valid = best_p > thr;
    win_id    = win_valid ? best_i : '0;
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   src_lvl,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_CTX-1:0] ctx_irq
);
  localparam int IDW = $clog2(NUM_SRC+1);
  localparam int CW  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  // Register state
  logic [PRIO_W-1:0]  prio_q [1:NUM_SRC];
  logic [NUM_SRC:1]   en_q   [NUM_CTX];
  logic [PRIO_W-1:0]  thr_q  [NUM_CTX];

  // Gateway state and strobes
  logic [NUM_SRC:1] pend_v, busy_v, take_v, done_v;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  // Arbitration results
  logic [IDW-1:0] win_id    [NUM_CTX];
  logic           win_valid [NUM_CTX];

  // Decode
  sel_e           d_sel;
  logic [IDW-1:0] d_idx;
  logic [CW-1:0]  d_ctx;

  logic wr, rd, claim_rd, id_ok;
  logic [IDW-1:0]    done_id;
  logic [DATA_W-1:0] en_word;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  irq_hub_decode #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dec (
    .addr(req_addr), .sel(d_sel), .idx(d_idx), .ctx(d_ctx)
  );

  // Gateways and flattened priorities, one per source
  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
    irq_hub_gate u_gate (
      .clk(clk), .rst(rst), .lvl(src_lvl[g]),
      .take(take_v[g]), .done(done_v[g]),
      .pend(pend_v[g]), .busy(busy_v[g])
    );
    assign prio_flat[(g-1)*PRIO_W +: PRIO_W] = prio_q[g];
  end

  // One arbiter per context
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_hub_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .pend(pend_v), .en(en_q[c]), .prio(prio_flat), .thr(thr_q[c]),
      .win_id(win_id[c]), .win_valid(win_valid[c])
    );

    // R6: the winner is pending, enabled here and above this threshold
    p_win_elig_r6: assert property (@(posedge clk) disable iff (rst)
      win_valid[c] |-> (pend_v[win_id[c]] && en_q[c][win_id[c]] &&
                        prio_q[win_id[c]] > thr_q[c]));

    // R5: the top threshold value keeps the line low
    p_thr_mask_r5: assert property (@(posedge clk) disable iff (rst)
      (thr_q[c] == {PRIO_W{1'b1}}) |=> !ctx_irq[c]);
  end

  // Claim and completion strobes
  assign claim_rd = rd && (d_sel == SEL_CLAIM) && win_valid[d_ctx];
  assign id_ok    = (req_wdata != '0) && (req_wdata <= DATA_W'(NUM_SRC));
  assign done_id  = IDW'(req_wdata);

  always_comb begin
    take_v = '0;
    done_v = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      take_v[i] = claim_rd && (win_id[d_ctx] == IDW'(i));
      done_v[i] = wr && (d_sel == SEL_CLAIM) && id_ok &&
                  (done_id == IDW'(i)) && en_q[d_ctx][i];
    end
  end

  // Enable word gather for reads
  always_comb begin
    en_word = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (IDW'(i / DATA_W) == d_idx) en_word[i % DATA_W] = en_q[d_ctx][i];
  end

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= NUM_SRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (wr) begin
      case (d_sel)
        SEL_PRIO: if (d_idx != '0) prio_q[d_idx] <= req_wdata[PRIO_W-1:0];
        SEL_EN: begin
          for (int i = 1; i <= NUM_SRC; i++)
            if (IDW'(i / DATA_W) == d_idx) en_q[d_ctx][i] <= req_wdata[i % DATA_W];
        end
        SEL_THR: thr_q[d_ctx] <= req_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // Registered read data and interrupt lines
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ctx_irq  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        case (d_sel)
          SEL_PRIO:  rd_data <= (d_idx == '0) ? '0 : DATA_W'(prio_q[d_idx]);
          SEL_EN:    rd_data <= en_word;
          SEL_THR:   rd_data <= DATA_W'(thr_q[d_ctx]);
          SEL_CLAIM: rd_data <= DATA_W'(win_id[d_ctx]);
          default:   rd_data <= '0;
        endcase
      end else begin
        rd_data <= '0;
      end
      for (int c = 0; c < NUM_CTX; c++) ctx_irq[c] <= win_valid[c];
    end
  end

  // R7: at most one source is taken per cycle
  p_one_take_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_v));

  // R11: every read request yields rd_valid on the next cycle
  p_rd_valid_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && d_sel == SEL_NONE) |=> (rd_data == '0));

endmodule

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
  localparam int NUM_SRC = 31;
  localparam int NUM_CTX = 2;
  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_SRC:1]   src_lvl = '0;
  logic               req_valid = 1'b0;
  logic               req_write = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [DATA_W-1:0]  req_wdata = '0;
  logic               rd_valid;
  logic [DATA_W-1:0]  rd_data;
  logic [NUM_CTX-1:0] ctx_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic last_rv;
  logic [31:0] got;

  always #10 clk = ~clk; // 50 MHz

  irq_hub #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(3), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u0 (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ctx_irq(ctx_irq)
  );

  function automatic logic [23:0] a_prio(input int id);
    return 24'(4 * id);
  endfunction
  function automatic logic [23:0] a_en(input int c);
    return 24'('h2000 + 'h80 * c);
  endfunction
  function automatic logic [23:0] a_thr(input int c);
    return 24'('h200000 + 'h1000 * c);
  endfunction
  function automatic logic [23:0] a_clm(input int c);
    return 24'('h200004 + 'h1000 * c);
  endfunction

  // Tasks start and end at a falling edge
  task automatic bus_wr(input logic [23:0] a, input logic [31:0] v);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [23:0] a, output logic [31:0] v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    v = rd_data;
    last_rv = rd_valid;
    req_valid = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {req, addr, write data, expected read-back}
  localparam logic [91:0] VEC [9] = '{
    {4'd2,  24'h000004, 32'h000000FF, 32'h00000007}, // R2 low 3 bits kept
    {4'd2,  24'h00007C, 32'h00000005, 32'h00000005}, // R2 last source
    {4'd2,  24'h000000, 32'h00000003, 32'h00000000}, // R2 source 0 slot
    {4'd3,  24'h002000, 32'hFFFFFFFF, 32'hFFFFFFFE}, // R3 ctx0, bit 0 zero
    {4'd3,  24'h002080, 32'h0000000F, 32'h0000000E}, // R3 ctx1
    {4'd4,  24'h201000, 32'h0000000F, 32'h00000007}, // R4 ctx1 threshold
    {4'd10, 24'h002004, 32'h00000001, 32'h00000000}, // R10 missing enable word
    {4'd10, 24'h000100, 32'h00000001, 32'h00000000}, // R10 past last priority
    {4'd10, 24'h203000, 32'h00000001, 32'h00000000}  // R10 past last context
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq lines", 32'(ctx_irq), 32'h0);
    bus_rd(a_clm(0), got);  check("R1 claim ctx0", got, 32'h0);
    check("R11 rd_valid after read", 32'(last_rv), 32'h1);
    bus_rd(a_prio(7), got); check("R1 priority 7", got, 32'h0);
    bus_rd(a_en(1), got);   check("R1 enable ctx1", got, 32'h0);
    bus_rd(a_thr(0), got);  check("R1 threshold ctx0", got, 32'h0);
    step(1);
    check("R11 rd_valid idle", 32'(rd_valid), 32'h0);

    // Register round trips from the table
    for (int k = 0; k < 9; k++) begin
      bus_wr(VEC[k][87:64], VEC[k][63:32]);
      bus_rd(VEC[k][87:64], got);
      check($sformatf("R%0d table entry %0d", VEC[k][91:88], k), got, VEC[k][31:0]);
    end

    rst = 1'b1; step(2); rst = 1'b0;

    // Setup: priorities and enables
    bus_wr(a_prio(3), 2); bus_wr(a_prio(5), 2);
    bus_wr(a_prio(7), 6); bus_wr(a_prio(9), 0);
    bus_wr(a_en(0), 32'h000002A8);  // sources 3,5,7,9
    bus_wr(a_en(1), 32'h00000020);  // source 5

    src_lvl[3] = 1'b1; src_lvl[5] = 1'b1; src_lvl[9] = 1'b1;
    step(2);
    check("R5 irq ctx0 raised", 32'(ctx_irq[0]), 32'h1);
    check("R5 irq ctx1 raised", 32'(ctx_irq[1]), 32'h1);

    bus_rd(a_clm(0), got); check("R6 tie lower id", got, 32'd3);
    bus_rd(a_clm(0), got); check("R6 next winner", got, 32'd5);
    bus_rd(a_clm(0), got); check("R6 priority zero never", got, 32'd0);
    bus_rd(a_clm(1), got); check("R7 locked for other ctx", got, 32'd0);
    step(1);
    check("R7 irq lines drop", 32'(ctx_irq), 32'h0);
    step(3);
    bus_rd(a_clm(0), got); check("R7 held-high source stays locked", got, 32'd0);

    // R9 completion from a context without the enable
    bus_wr(a_clm(1), 3);
    step(2);
    bus_rd(a_clm(0), got); check("R9 foreign completion ignored", got, 32'd0);

    // R8 completion, then exact re-pend timing
    bus_wr(a_clm(0), 3);
    bus_rd(a_clm(0), got); check("R8 no re-pend same edge", got, 32'd0);
    bus_rd(a_clm(0), got); check("R8 re-pend next cycle", got, 32'd3);

    bus_wr(a_clm(1), 5);
    step(1);
    bus_rd(a_clm(1), got); check("R8 completion from ctx1", got, 32'd5);

    // R5 threshold handling
    src_lvl[7] = 1'b1;
    bus_wr(a_thr(0), 6);
    step(3);
    check("R5 equal priority masked", 32'(ctx_irq[0]), 32'h0);
    bus_wr(a_thr(0), 5);
    step(1);
    check("R5 above threshold raises", 32'(ctx_irq[0]), 32'h1);
    bus_rd(a_clm(0), got); check("R6 highest priority", got, 32'd7);
    bus_wr(a_clm(0), 7);
    step(2);
    bus_wr(a_thr(0), 7);
    step(2);
    check("R5 threshold 7 masks all", 32'(ctx_irq[0]), 32'h0);
    bus_rd(a_clm(0), got); check("R6 claim respects threshold", got, 32'd0);

    summary();
    $finish;
  end

endmodule